// File: doc/BRIEF.md
# Serial Bit-Manipulation Datapath

This block edits a 24-bit word one bit at a time by rotating it through a one-bit full adder. A load strobe captures the word and a 12-bit command. While the shift window input is high, the word moves right by one place on each clock. Each clock, the adder output is written into the most significant bit. The command chooses the two adder operands, which gives plain rotation, doubling, decrement, sign fill or constant fill over a full 24-step pass. The adder carry is held in a flip-flop between steps.

A 5-bit position counter is loaded with the inverted K field of the command. It advances on each step until it saturates at all ones. The step on which it is saturated and still armed is the target step. On that step the written bit can be forced high, forced low or inverted. Because the counter needs exactly K steps to saturate, the bit acted on is the original bit K. A test flag can record the operand seen at the target step, or whether any operand bit was one during the pass.

Top module: `sa_bitmanip`

## Requirements
- R1: While reset is high, on each clock the word output becomes 0 and the test flag becomes 0.
- R2: A load strobe copies the data input into the word and clears the test flag one clock later. The carry is cleared to 0 at the same time, and the position counter is set to the inverted K field.
- R3: When neither load nor shift window is high, the word does not change.
- R4: Take a command with A-operand select 00 (word bit 0), B select 0 (zero) and action 00 (none). After 24 shift steps the word equals the loaded value.
- R5: Command bits [11:10] pick the A operand: 00 = word bit 0, 01 = word bit 23, 10 = constant 0, 11 = constant 1. Bit 9 picks the B operand: 0 = zero, 1 = word bit 0. Over 24 steps starting from a carry of 0, the results are: 00 with B=1 gives the loaded value doubled modulo 2^24; 11 with B=1 gives the loaded value minus 1 modulo 2^24; 01 with B=0 fills every bit with the loaded bit 23; 10 with B=1 leaves the word unchanged; 11 with B=0 gives all ones.
- R6: On a step, the word moves right by one place, so new bits 22..0 equal old bits 23..1.
- R7: Command bits [8:7] choose the action on the target bit: 00 none, 01 force 1, 10 force 0, 11 invert. Command bits [4:0] hold K. After a rotation pass, only bit K differs from what R4/R5 would give.
- R8: The target step happens at most once per command. K=0 acts on bit 0 and K=23 acts on bit 23. A K of 24 to 31 acts on no bit within a 24-step pass.
- R9: Command bits [6:5] choose the test mode: 00 never set, 01 set if the A operand is 1 at the target step, 10 set if it is 0 at the target step, 11 set if the A operand is 1 on any step. The flag only rises on a step.
- R10: When load and the shift window are high on the same clock, the load wins and no shift takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Captures data_i and instr_i, and starts a command |
| instr_i | input | 12 | Command: A select, B select, action, test mode, K |
| data_i | input | 24 | Word to load |
| shift_en_i | input | 1 | Shift window; one step per clock while high |
| areg_o | output | 24 | Current word |
| test_o | output | 1 | Test flag |

## Verification
A wrong carry or operand choice corrupts bits that reach the top of the word on the very next step. It shows as a wrong arithmetic result after the 24-step pass. A position counter that is off by one moves the edited bit to a neighbour, or makes the test flag report the wrong bit. Both are visible on the ports at the end of the pass. A counter that fails to saturate or fails to disarm produces a second edit, which is caught at the port by the K boundary cases and the out-of-range K case.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;

    localparam int K_W = 5;

    typedef enum logic [1:0] {
        ASEL_LSB  = 2'b00,
        ASEL_MSB  = 2'b01,
        ASEL_ZERO = 2'b10,
        ASEL_ONE  = 2'b11
    } asel_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_FLIP = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        TST_NONE = 2'b00,
        TST_ONE  = 2'b01,
        TST_ZERO = 2'b10,
        TST_ANY  = 2'b11
    } tmode_e;

    typedef struct packed {
        asel_e            asel;
        logic             bsel;
        act_e             act;
        tmode_e           tmode;
        logic [K_W-1:0]   k;
    } cmd_t;

    localparam int CMD_W = $bits(cmd_t);

    function automatic logic act_bit(act_e a, logic s);
        case (a)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_FLIP: return ~s;
            default:  return s;
        endcase
    endfunction

endpackage

// File: rtl/sa_jcount.sv
`timescale 1ns/1ps
module sa_jcount
    import sa_pkg::*;
#(
    parameter int W = K_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] k,
    output logic         hit
);
    localparam logic [W-1:0] J_MAX = '1;

    logic [W-1:0] j_q;
    logic         arm_q;

    assign hit = arm_q && (j_q == J_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            j_q   <= '0;
            arm_q <= 1'b0;
        end else if (load) begin
            j_q   <= ~k;
            arm_q <= 1'b1;
        end else if (step) begin
            if (hit)
                arm_q <= 1'b0;
            if (arm_q && (j_q != J_MAX))
                j_q <= j_q + 1'b1;
        end
    end
endmodule

// File: rtl/sa_serial_adder.sv
`timescale 1ns/1ps
module sa_serial_adder (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    input  logic a_op,
    input  logic b_op,
    output logic sum
);
    logic cy_q;

    assign sum = a_op ^ b_op ^ cy_q;

    always_ff @(posedge clk) begin
        if (rst || load)
            cy_q <= 1'b0;
        else if (step) begin
            if (a_op && b_op)
                cy_q <= 1'b1;
            else if (!a_op && !b_op)
                cy_q <= 1'b0;
        end
    end
endmodule

// File: rtl/sa_testflag.sv
`timescale 1ns/1ps
module sa_testflag
    import sa_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step,
    input  tmode_e mode,
    input  logic   hit,
    input  logic   a_op,
    output logic   flag
);
    logic set_now;

    always_comb begin
        case (mode)
            TST_ONE:  set_now = hit && a_op;
            TST_ZERO: set_now = hit && !a_op;
            TST_ANY:  set_now = a_op;
            default:  set_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || load)
            flag <= 1'b0;
        else if (step && set_now)
            flag <= 1'b1;
    end
endmodule

// File: rtl/sa_bitmanip.sv
`timescale 1ns/1ps
module sa_bitmanip
    import sa_pkg::*;
#(
    parameter int A_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CMD_W-1:0] instr_i,
    input  logic [A_W-1:0]   data_i,
    input  logic             shift_en_i,
    output logic [A_W-1:0]   areg_o,
    output logic             test_o
);
    localparam int MSB = A_W - 1;

    cmd_t           cmd_in;
    cmd_t           cmd_q;
    logic [A_W-1:0] a_q;
    logic           step;
    logic           a_op;
    logic           b_op;
    logic           sum;
    logic           hit_w;
    logic           wbit;

    assign cmd_in = cmd_t'(instr_i);
    assign step   = shift_en_i && !load_i;

    always_comb begin
        case (cmd_q.asel)
            ASEL_LSB:  a_op = a_q[0];
            ASEL_MSB:  a_op = a_q[MSB];
            ASEL_ZERO: a_op = 1'b0;
            default:   a_op = 1'b1;
        endcase
    end

    assign b_op = cmd_q.bsel & a_q[0];
    assign wbit = hit_w ? act_bit(cmd_q.act, sum) : sum;

    sa_serial_adder u_add (
        .clk  (clk),
        .rst  (rst),
        .load (load_i),
        .step (step),
        .a_op (a_op),
        .b_op (b_op),
        .sum  (sum)
    );

    sa_jcount #(.W(K_W)) u_jc (
        .clk  (clk),
        .rst  (rst),
        .load (load_i),
        .step (step),
        .k    (cmd_in.k),
        .hit  (hit_w)
    );

    sa_testflag u_tf (
        .clk  (clk),
        .rst  (rst),
        .load (load_i),
        .step (step),
        .mode (cmd_q.tmode),
        .hit  (hit_w),
        .a_op (a_op),
        .flag (test_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            cmd_q <= '0;
        end else if (load_i) begin
            a_q   <= data_i;
            cmd_q <= cmd_in;
        end else if (step) begin
            a_q   <= {wbit, a_q[MSB:1]};
        end
    end

    assign areg_o = a_q;
endmodule

// File: rtl/sa_bitmanip_chk.sv
`timescale 1ns/1ps
module sa_bitmanip_chk #(
    parameter int A_W = 24
) (
    input logic           clk,
    input logic           rst,
    input logic           load_i,
    input logic           shift_en_i,
    input logic [A_W-1:0] data_i,
    input logic [A_W-1:0] areg_o,
    input logic           test_o,
    input logic           hit
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (areg_o == '0 && !test_o));

    // R2
    a_r2_load_word: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (areg_o == $past(data_i) && !test_o));

    // R3
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !shift_en_i) |=> $stable(areg_o));

    // R6
    a_r6_shift_right: assert property (@(posedge clk) disable iff (rst)
        (!load_i && shift_en_i) |=> (areg_o[A_W-2:0] == $past(areg_o[A_W-1:1])));

    // R8
    a_r8_single_target: assert property (@(posedge clk) disable iff (rst)
        (hit && shift_en_i && !load_i) |=> !hit);

    // R9
    a_r9_flag_rises_on_step: assert property (@(posedge clk) disable iff (rst)
        $rose(test_o) |-> $past(shift_en_i && !load_i));
endmodule

bind sa_bitmanip sa_bitmanip_chk #(.A_W(A_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .shift_en_i (shift_en_i),
    .data_i     (data_i),
    .areg_o     (areg_o),
    .test_o     (test_o),
    .hit        (hit_w)
);

// File: tb/sim_sa_bitmanip.sv
`timescale 1ns/1ps
module sim_sa_bitmanip;
    localparam int AW = 24;
    localparam logic [AW-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [11:0]   instr_i = '0;
    logic [AW-1:0] data_i = '0;
    logic          shift_en_i = 1'b0;
    logic [AW-1:0] areg_o;
    logic          test_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic          t;
        string         req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    sa_bitmanip #(.A_W(AW)) u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .instr_i(instr_i),
        .data_i(data_i), .shift_en_i(shift_en_i),
        .areg_o(areg_o), .test_o(test_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(logic [1:0] as, logic bs, logic [1:0] ac,
                                       logic [1:0] tm, logic [4:0] k);
        return {as, bs, ac, tm, k};
    endfunction

    task automatic do_load(logic [11:0] ins, logic [AW-1:0] d);
        @(negedge clk);
        load_i = 1'b1; instr_i = ins; data_i = d;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic run_cmd(logic [11:0] ins, logic [AW-1:0] d,
                           logic [AW-1:0] ea, logic et, string req);
        exp_t e;
        do_load(ins, d);
        shift_en_i = 1'b1;
        repeat (AW) @(negedge clk);
        shift_en_i = 1'b0;
        e.a = ea; e.t = et; e.req = req;
        sb.push_back(e);
    endtask

    // monitor: compare each expected result against the ports
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() != 0);
            e = sb.pop_front();
            chk({e.req, " word"}, 32'(areg_o), 32'(e.a));
            chk({e.req, " flag"}, 32'(test_o), 32'(e.t));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] d;
        repeat (3) @(negedge clk);
        chk("R1 reset word", 32'(areg_o), 32'h0);
        chk("R1 reset flag", 32'(test_o), 32'h0);
        rst = 1'b0;

        // R2 load, R3 hold
        d = 24'hA5C33C;
        do_load(mk(2'b00, 1'b0, 2'b00, 2'b00, 5'd0), d);
        chk("R2 load", 32'(areg_o), 32'(d));
        repeat (3) @(negedge clk);
        chk("R3 idle hold", 32'(areg_o), 32'(d));

        // R6 single step then finish pass (R4)
        shift_en_i = 1'b1;
        @(negedge clk);
        shift_en_i = 1'b0;
        chk("R6 one step", 32'(areg_o), 32'({d[0], d[AW-1:1]}));
        @(negedge clk);
        shift_en_i = 1'b1;
        repeat (AW-1) @(negedge clk);
        shift_en_i = 1'b0;
        chk("R4 paused rotation", 32'(areg_o), 32'(d));

        // R10 load wins over shift
        @(negedge clk);
        load_i = 1'b1; shift_en_i = 1'b1; data_i = 24'h123456;
        instr_i = mk(2'b00, 1'b0, 2'b00, 2'b00, 5'd0);
        @(negedge clk);
        load_i = 1'b0; shift_en_i = 1'b0;
        chk("R10 load priority", 32'(areg_o), 32'h123456);

        // R4 rotation
        run_cmd(mk(2'b00,1'b0,2'b00,2'b00,5'd9), 24'h5A0F71, 24'h5A0F71, 1'b0, "R4");
        // R7 actions
        run_cmd(mk(2'b00,1'b0,2'b01,2'b00,5'd5), 24'h000F00, 24'h000F20, 1'b0, "R7 set");
        run_cmd(mk(2'b00,1'b0,2'b11,2'b00,5'd10), 24'hF0F0F0, 24'hF0F4F0, 1'b0, "R7 flip");
        // R8 boundaries
        run_cmd(mk(2'b00,1'b0,2'b10,2'b00,5'd0), 24'hFFFFFF, 24'hFFFFFE, 1'b0, "R8 k0 clear");
        run_cmd(mk(2'b00,1'b0,2'b11,2'b00,5'd23), 24'h00ABCD, 24'h80ABCD, 1'b0, "R8 k23 flip");
        run_cmd(mk(2'b00,1'b0,2'b01,2'b00,5'd27), 24'h000000, 24'h000000, 1'b0, "R8 k27 none");
        // R5 operand selections
        d = 24'hC12345;
        run_cmd(mk(2'b00,1'b1,2'b00,2'b00,5'd31), d, (d << 1) & ONES, 1'b0, "R5 double");
        run_cmd(mk(2'b11,1'b1,2'b00,2'b00,5'd31), d, (d - 1) & ONES, 1'b0, "R5 decrement");
        run_cmd(mk(2'b11,1'b1,2'b00,2'b00,5'd31), 24'h0, ONES, 1'b0, "R5 decrement wrap");
        run_cmd(mk(2'b01,1'b0,2'b00,2'b00,5'd31), 24'h812345, ONES, 1'b0, "R5 sign fill 1");
        run_cmd(mk(2'b01,1'b0,2'b00,2'b00,5'd31), 24'h7FFFFF, 24'h0, 1'b0, "R5 sign fill 0");
        run_cmd(mk(2'b10,1'b1,2'b00,2'b00,5'd31), d, d, 1'b0, "R5 zero plus word");
        run_cmd(mk(2'b11,1'b0,2'b00,2'b00,5'd31), d, ONES, 1'b0, "R5 ones");
        // R9 test modes
        run_cmd(mk(2'b00,1'b0,2'b00,2'b01,5'd3), 24'h000008, 24'h000008, 1'b1, "R9 one hit");
        run_cmd(mk(2'b00,1'b0,2'b00,2'b01,5'd3), 24'hFFFFF7, 24'hFFFFF7, 1'b0, "R9 one miss");
        run_cmd(mk(2'b00,1'b0,2'b00,2'b10,5'd3), 24'hFFFFF7, 24'hFFFFF7, 1'b1, "R9 zero hit");
        run_cmd(mk(2'b00,1'b0,2'b00,2'b11,5'd3), 24'h400000, 24'h400000, 1'b1, "R9 any set");
        run_cmd(mk(2'b00,1'b0,2'b00,2'b11,5'd3), 24'h000000, 24'h000000, 1'b0, "R9 any clear");
        run_cmd(mk(2'b00,1'b0,2'b00,2'b00,5'd3), 24'hFFFFFF, 24'hFFFFFF, 1'b0, "R9 mode none");

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule